// File: doc/BRIEF.md
# Quaternary Symbol Channel Port

This block sits between a transceiver core and a channel-unit data port that carries 2-bit quaternary line symbols. Each symbol has a sign bit and a magnitude bit. The port has a symbol-clock pin and two data pins in each direction, and it works in one of two ways. In parallel operation the two data pins carry sign and magnitude side by side, one symbol per symbol clock. In serial operation one data pin carries the symbol bits in sequence at twice the symbol rate, the other receive pin carries the bit clock, and the symbol clock marks where each pair of bits starts.

The block makes its bit and symbol timing from a fast system clock through a programmable divider. In parallel-slave operation it follows an external symbol clock instead. Symbols from the core are loaded into a hold register by a strobe and driven onto the receive pins. Symbols arriving on the transmit pins are handed to the core as a 2-bit word with a one-cycle valid pulse.

Top module: `quat_chan_if`

## Requirements
- R1: While reset is low (asynchronous, active low, released after two system-clock edges), `pin_rq`, `pin_qclk_o`, `tx_sym` and `tx_sym_vld` are all 0.
- R2: With divider value N = `cfg_div` ≥ 1, `pin_qclk_o` has a period of 4N system cycles and is high for the first 2N. In serial modes the bit clock on `pin_rq[0]` has a period of 2N, and each rising edge of `pin_qclk_o` falls on a rising edge of the bit clock. Reset clears the stored divider value, and while that value is 0 both clocks stay low.
- R3: In parallel master mode (`cfg_mode` = 00), `pin_rq` = {sign, magnitude} of the held receive symbol, and it changes only at a rising edge of `pin_qclk_o`.
- R4: In parallel master mode, `pin_tq` = {sign, magnitude} is sampled at the falling edge of `pin_qclk_o`. The sample appears on `tx_sym` with `tx_sym_vld` high one cycle later.
- R5: In serial modes, `pin_rq[1]` carries the two bits of the held symbol and changes only at rising bit-clock edges. The first bit of a symbol appears at the rising edge of `pin_qclk_o`.
- R6: In serial modes, `pin_tq[1]` is sampled at the two falling bit-clock edges of each symbol period. The assembled symbol is delivered after the second of these edges. `pin_tq[0]` has no effect.
- R7: `cfg_mode` = 10 sends and expects the magnitude bit first. `cfg_mode` = 11 sends and expects the sign bit first. This holds in both directions.
- R8: A change of `cfg_mode` takes effect only at the next rising edge of the internal symbol clock.
- R9: In parallel slave mode (`cfg_mode` = 01), `pin_qclk_i` passes through a two-flop synchronizer and is edge-detected. `pin_rq` updates at its rising edge. `pin_tq` is captured on the rising edge when `cfg_cap_rise` = 1 and on the falling edge when `cfg_cap_rise` = 0. `pin_qclk_o` stays 0 in this mode.
- R10: The receive hold register loads `rx_sym` only in a cycle where `rx_sym_vld` is high. Changes to `rx_sym` at other times do not reach the pins.
- R11: `tx_sym_vld` is high for one cycle per delivered symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Divider value N; 0 keeps the clocks idle |
| cfg_mode | input | 2 | 00 parallel master, 01 parallel slave, 10 serial magnitude-first, 11 serial sign-first |
| cfg_cap_rise | input | 1 | Parallel slave transmit capture edge: 1 rising, 0 falling |
| rx_sym | input | 2 | Symbol from the core {sign, magnitude} |
| rx_sym_vld | input | 1 | Load strobe for `rx_sym` |
| tx_sym | output | 2 | Received transmit-pin symbol {sign, magnitude} |
| tx_sym_vld | output | 1 | One-cycle valid for `tx_sym` |
| pin_rq | output | 2 | Receive pins: {sign, magnitude} in parallel, {data, bit clock} in serial |
| pin_tq | input | 2 | Transmit pins: {sign, magnitude} in parallel, data on bit 1 in serial |
| pin_qclk_o | output | 1 | Generated symbol clock |
| pin_qclk_i | input | 1 | External symbol clock for parallel slave mode |

## Verification
The bench builds the block with a 4-bit divider field and sweeps N from 1 to 3 in every generated mode. This covers the shortest possible quarter period of one system cycle, where sampling and update edges sit next to each other. For each N, all four symbol values run through both directions and both serial bit orders, so every sign/magnitude combination meets every framing position. One mode switch in the middle of a symbol, the slave capture-edge choice and mid-run resets are also checked.

// File: rtl/qsi_pkg.sv
package qsi_pkg;
  typedef enum logic [1:0] {
    QM_PAR_MST = 2'b00,
    QM_PAR_SLV = 2'b01,
    QM_SER_MAG = 2'b10,
    QM_SER_SGN = 2'b11
  } qmode_e;

  function automatic logic is_ser(qmode_e m);
    return (m == QM_SER_MAG) || (m == QM_SER_SGN);
  endfunction

  // maps {sign,mag} to {first,second} on the wire; the map is its own inverse
  function automatic logic [1:0] wire_order(logic [1:0] v, qmode_e m);
    return (m == QM_SER_SGN) ? v : {v[0], v[1]};
  endfunction
endpackage

// File: rtl/qsi_rst_sync.sv
module qsi_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/qsi_clkgen.sv
module qsi_clkgen
  import qsi_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  qmode_e           cfg_mode,
  output logic [3:0]       enter,
  output qmode_e           mode_eff,
  output qmode_e           mode_q,
  output logic             bclk,
  output logic             qclk
);
  logic [DIV_W-1:0] rate_q, rate_d, cnt_q, cnt_d;
  logic [1:0]       qtr_q, qtr_d, qtr_n;
  logic             bclk_q, bclk_d, qclk_q, qclk_d;
  qmode_e           mode_r, mode_d;
  logic             idle, wrap, latch;

  assign idle  = (rate_q == '0);
  assign wrap  = !idle && (cnt_q == rate_q - DIV_W'(1));
  assign qtr_n = qtr_q + 2'd1;

  for (genvar i = 0; i < 4; i++) begin : g_enter
    assign enter[i] = wrap && (qtr_n == 2'(i));
  end

  assign latch    = idle || enter[0];
  assign mode_eff = latch ? cfg_mode : mode_r;

  always_comb begin
    rate_d = latch ? cfg_div : rate_q;
    mode_d = latch ? cfg_mode : mode_r;
    if (idle) begin
      cnt_d  = '0;
      qtr_d  = 2'd3;
      bclk_d = 1'b0;
      qclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      qtr_d  = qtr_n;
      bclk_d = ~qtr_n[0];
      qclk_d = ~qtr_n[1];
    end else begin
      cnt_d  = cnt_q + DIV_W'(1);
      qtr_d  = qtr_q;
      bclk_d = bclk_q;
      qclk_d = qclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      mode_r <= QM_PAR_MST;
      cnt_q  <= '0;
      qtr_q  <= 2'd3;
      bclk_q <= 1'b0;
      qclk_q <= 1'b0;
    end else begin
      rate_q <= rate_d;
      mode_r <= mode_d;
      cnt_q  <= cnt_d;
      qtr_q  <= qtr_d;
      bclk_q <= bclk_d;
      qclk_q <= qclk_d;
    end
  end

  assign mode_q = mode_r;
  assign bclk   = bclk_q;
  assign qclk   = qclk_q;

  // symbol clock rises only together with a bit clock rise
  assert_sym_on_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qclk_q) |-> $rose(bclk_q));
  // bit clock moves only when the divider count restarts
  assert_bclk_on_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bclk_q) && !idle && !$past(idle)) |-> (cnt_q == '0));
  // mode register moves only at a symbol boundary or while idle
  assert_mode_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_r) |-> ($rose(qclk_q) || $past(idle)));
endmodule

// File: rtl/qsi_slave_sync.sv
module qsi_slave_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qclk_i,
  input  logic [1:0] tq_i,
  input  logic       cap_rise,
  output logic       ext_rise,
  output logic       ext_evt,
  output logic [1:0] tq_s
);
  logic [2:0] sq_q;
  logic [1:0] td1_q, td2_q;
  logic       fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q  <= '0;
      td1_q <= '0;
      td2_q <= '0;
    end else begin
      sq_q  <= {sq_q[1:0], qclk_i};
      td1_q <= tq_i;
      td2_q <= td1_q;
    end
  end

  assign ext_rise = sq_q[1] & ~sq_q[2];
  assign fall     = ~sq_q[1] & sq_q[2];
  assign ext_evt  = cap_rise ? ext_rise : fall;
  assign tq_s     = td2_q;
endmodule

// File: rtl/qsi_rx_drive.sv
module qsi_rx_drive
  import qsi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_sym,
  input  logic       rx_sym_vld,
  input  logic       enter0,
  input  logic       enter2,
  input  logic       ext_rise,
  input  qmode_e     mode_eff,
  input  qmode_e     mode_q,
  input  logic       bclk,
  output logic [1:0] pin_rq
);
  logic [1:0] hold_q, hold_d, par_q, par_d;
  logic       ser_q, ser_d, sec_q, sec_d;
  logic       par_ld;

  assign par_ld = (enter0 && (mode_eff == QM_PAR_MST)) ||
                  (ext_rise && (mode_q == QM_PAR_SLV));

  always_comb begin
    hold_d = rx_sym_vld ? rx_sym : hold_q;
    par_d  = par_ld ? hold_q : par_q;
    ser_d  = ser_q;
    sec_d  = sec_q;
    if (enter0 && is_ser(mode_eff)) begin
      {ser_d, sec_d} = wire_order(hold_q, mode_eff);
    end else if (enter2 && is_ser(mode_q)) begin
      ser_d = sec_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      par_q  <= '0;
      ser_q  <= 1'b0;
      sec_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      par_q  <= par_d;
      ser_q  <= ser_d;
      sec_q  <= sec_d;
    end
  end

  assign pin_rq[1] = is_ser(mode_q) ? ser_q : par_q[1];
  assign pin_rq[0] = is_ser(mode_q) ? bclk  : par_q[0];

  // parallel outputs move only on a symbol clock rise (internal or external)
  assert_par_on_qrise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(par_q) |-> $past(enter0 || ext_rise));
  // serial data moves only on a bit clock rise
  assert_ser_on_brise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_q) |-> $past(enter0 || enter2));
endmodule

// File: rtl/qsi_tx_capture.sv
module qsi_tx_capture
  import qsi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter1,
  input  logic       enter2,
  input  logic       enter3,
  input  logic       ext_evt,
  input  qmode_e     mode_q,
  input  logic [1:0] pin_tq,
  input  logic [1:0] slv_tq,
  output logic [1:0] tx_sym,
  output logic       tx_sym_vld
);
  logic [1:0] sym_q, sym_d;
  logic       vld_q, vld_d, first_q, first_d;

  always_comb begin
    sym_d   = sym_q;
    vld_d   = 1'b0;
    first_d = first_q;
    if (enter2 && (mode_q == QM_PAR_MST)) begin
      sym_d = pin_tq;
      vld_d = 1'b1;
    end
    if (ext_evt && (mode_q == QM_PAR_SLV)) begin
      sym_d = slv_tq;
      vld_d = 1'b1;
    end
    if (is_ser(mode_q)) begin
      if (enter1) first_d = pin_tq[1];
      if (enter3) begin
        sym_d = wire_order({first_q, pin_tq[1]}, mode_q);
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q   <= '0;
      vld_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      sym_q   <= sym_d;
      vld_q   <= vld_d;
      first_q <= first_d;
    end
  end

  assign tx_sym     = sym_q;
  assign tx_sym_vld = vld_q;

  assert_par_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enter2 && (mode_q == QM_PAR_MST)) |=> tx_sym_vld);
  assert_ser_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enter3 && is_ser(mode_q)) |=> tx_sym_vld);
  assert_slave_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_evt && (mode_q == QM_PAR_SLV)) |=> tx_sym_vld);
  assert_vld_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sym_vld |=> !tx_sym_vld);
endmodule

// File: rtl/quat_chan_if.sv
module quat_chan_if
  import qsi_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_cap_rise,
  input  logic [1:0]       rx_sym,
  input  logic             rx_sym_vld,
  output logic [1:0]       tx_sym,
  output logic             tx_sym_vld,
  output logic [1:0]       pin_rq,
  input  logic [1:0]       pin_tq,
  output logic             pin_qclk_o,
  input  logic             pin_qclk_i
);
  logic       rst_s_n;
  logic [3:0] enter;
  qmode_e     mode_eff, mode_q;
  logic       bclk, qclk, ext_rise, ext_evt;
  logic [1:0] slv_tq;

  qsi_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_s_n)
  );

  qsi_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cfg_div  (cfg_div),
    .cfg_mode (qmode_e'(cfg_mode)),
    .enter    (enter),
    .mode_eff (mode_eff),
    .mode_q   (mode_q),
    .bclk     (bclk),
    .qclk     (qclk)
  );

  qsi_slave_sync u_slv (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .qclk_i   (pin_qclk_i),
    .tq_i     (pin_tq),
    .cap_rise (cfg_cap_rise),
    .ext_rise (ext_rise),
    .ext_evt  (ext_evt),
    .tq_s     (slv_tq)
  );

  qsi_rx_drive u_rx (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .rx_sym     (rx_sym),
    .rx_sym_vld (rx_sym_vld),
    .enter0     (enter[0]),
    .enter2     (enter[2]),
    .ext_rise   (ext_rise),
    .mode_eff   (mode_eff),
    .mode_q     (mode_q),
    .bclk       (bclk),
    .pin_rq     (pin_rq)
  );

  qsi_tx_capture u_tx (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .enter1     (enter[1]),
    .enter2     (enter[2]),
    .enter3     (enter[3]),
    .ext_evt    (ext_evt),
    .mode_q     (mode_q),
    .pin_tq     (pin_tq),
    .slv_tq     (slv_tq),
    .tx_sym     (tx_sym),
    .tx_sym_vld (tx_sym_vld)
  );

  assign pin_qclk_o = qclk & (mode_q != QM_PAR_SLV);

  // the symbol clock pin is quiet whenever the port follows an external clock
  assert_slave_no_qclk_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_q == QM_PAR_SLV) |-> !pin_qclk_o);
endmodule

// File: tb/sim_quat_chan_if.sv
module sim_quat_chan_if;
  localparam int DIV_W  = 4;
  localparam int CLK_NS = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DIV_W-1:0] cfg_div;
  logic [1:0]       cfg_mode;
  logic             cfg_cap_rise;
  logic [1:0]       rx_sym;
  logic             rx_sym_vld;
  logic [1:0]       tx_sym;
  logic             tx_sym_vld;
  logic [1:0]       pin_rq;
  logic [1:0]       pin_tq;
  logic             pin_qclk_o;
  logic             pin_qclk_i;

  int n_chk = 0;
  int n_bad = 0;
  int vld_cnt = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  quat_chan_if #(.DIV_W(DIV_W)) u0 (.*);

  always @(negedge clk) if (tx_sym_vld) vld_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_qrise();
    logic p;
    bit hit;
    p = pin_qclk_o;
    hit = 0;
    while (!hit) begin
      @(negedge clk);
      hit = pin_qclk_o && !p;
      p = pin_qclk_o;
    end
  endtask

  task automatic wait_brise();
    logic p;
    bit hit;
    p = pin_rq[0];
    hit = 0;
    while (!hit) begin
      @(negedge clk);
      hit = pin_rq[0] && !p;
      p = pin_rq[0];
    end
  endtask

  task automatic wait_vld();
    do @(negedge clk); while (!tx_sym_vld);
  endtask

  task automatic load_rx(input logic [1:0] s);
    rx_sym = s; rx_sym_vld = 1'b1;
    @(negedge clk);
    rx_sym_vld = 1'b0;
  endtask

  task automatic chk_zero(input string req);
    chk(req, {pin_rq, pin_qclk_o, tx_sym, tx_sym_vld}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int cyc, v0;
    logic [1:0] wo;
    rst_n = 1'b0; cfg_div = '0; cfg_mode = 2'b00; cfg_cap_rise = 1'b1;
    rx_sym = '0; rx_sym_vld = 1'b0; pin_tq = '0; pin_qclk_i = 1'b0;
    repeat (3) @(negedge clk);
    chk_zero("R1 outputs in reset");
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 idle with zero divider", {pin_qclk_o, pin_rq}, 0);

    for (int n = 1; n <= 3; n++) begin
      cfg_div = DIV_W'(n);
      cfg_mode = 2'b00;
      wait_qrise(); wait_qrise();
      cyc = 0;
      wait_qrise();
      do begin @(negedge clk); cyc++; end while (!(pin_qclk_o && cyc > 1 && !u_prev_q));
      chk("R2 symbol period", cyc, 4 * n);
      for (int s = 0; s < 4; s++) begin
        load_rx(2'(s));
        pin_tq = 2'(3 - s);
        wait_qrise(); wait_qrise();
        chk("R3 parallel rx symbol", pin_rq, s);
        wait_vld();
        chk("R4 parallel tx symbol", tx_sym, 3 - s);
      end
      for (int m = 2; m <= 3; m++) begin
        cfg_mode = 2'(m);
        wait_qrise(); wait_qrise();
        chk("R2 qclk rise on bit rise", pin_rq[0], 1);
        cyc = 0;
        wait_brise();
        do begin @(negedge clk); cyc++; end while (!(pin_rq[0] && !u_prevb_q));
        chk("R2 bit period", cyc, 2 * n);
        for (int s = 0; s < 4; s++) begin
          wo = (m == 3) ? 2'(s) : {1'(s), 1'(s >> 1)};
          load_rx(2'(s));
          wait_qrise(); wait_qrise();
          chk("R5 R7 serial rx first bit", pin_rq[1], wo[1]);
          wait_brise();
          chk("R5 R7 serial rx second bit", pin_rq[1], wo[0]);
          wait_qrise();
          pin_tq = {wo[1], 1'(s)};
          wait_brise();
          pin_tq = {wo[0], ~1'(s)};
          wait_vld();
          chk("R6 R7 serial tx symbol", tx_sym, s);
        end
      end
    end

    // R8: mode switch mid-symbol waits for the boundary
    cfg_div = DIV_W'(3); cfg_mode = 2'b00;
    load_rx(2'b01);
    wait_qrise(); wait_qrise();
    cfg_mode = 2'b11;
    repeat (3) @(negedge clk);
    chk("R8 old mode holds to boundary", pin_rq[0], 1);
    wait_qrise();
    repeat (3) @(negedge clk);
    chk("R8 new mode after boundary", pin_rq[0], 0);

    // R10: hold register ignores rx_sym without strobe
    cfg_mode = 2'b00;
    wait_qrise(); wait_qrise();
    load_rx(2'b10);
    rx_sym = 2'b01;
    wait_qrise(); wait_qrise();
    chk("R10 hold ignores unstrobed input", pin_rq, 2);

    // R9: parallel slave
    cfg_mode = 2'b01; cfg_div = DIV_W'(2);
    repeat (40) @(negedge clk);
    chk("R9 slave qclk output quiet", pin_qclk_o, 0);
    cfg_cap_rise = 1'b1;
    pin_tq = 2'b10;
    load_rx(2'b01);
    repeat (4) @(negedge clk);
    v0 = vld_cnt;
    pin_qclk_i = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 slave rise capture", tx_sym, 2);
    chk("R11 one valid per slave edge", vld_cnt - v0, 1);
    chk("R9 slave rx update on rise", pin_rq, 1);
    pin_tq = 2'b01;
    repeat (4) @(negedge clk);
    v0 = vld_cnt;
    pin_qclk_i = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 slave fall ignored when rise chosen", tx_sym, 2);
    chk("R9 no valid on unchosen edge", vld_cnt - v0, 0);
    cfg_cap_rise = 1'b0;
    pin_tq = 2'b11;
    repeat (4) @(negedge clk);
    pin_qclk_i = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 slave rise ignored when fall chosen", tx_sym, 2);
    pin_qclk_i = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 slave fall capture", tx_sym, 3);

    // R1: asynchronous reset mid-run
    cfg_mode = 2'b11; cfg_div = DIV_W'(1);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_zero("R1 async reset clears outputs");
    cfg_div = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R2 divider cleared by reset", pin_qclk_o, 0);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  // previous-sample trackers for period measurement
  logic u_prev_q = 1'b0;
  logic u_prevb_q = 1'b0;
  always @(negedge clk) begin
    u_prev_q  <= pin_qclk_o;
    u_prevb_q <= pin_rq[0];
  end
endmodule